// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This unit is the internal data space of an 8051-class processor core. It holds a 256-byte scratch RAM, a bank of plain special-function registers (SFRs) and the stack pointer. The core issues one request per cycle on a single port. The request can be a byte read or write with direct or indirect addressing, a single-bit read, set, clear or write, or a stack push or pop. The result appears one cycle later.

Direct byte addresses in the upper half select the SFR space. Indirect and stack accesses always reach RAM, so the upper 128 RAM bytes are reachable only through them. Bit addresses form a second address space on the same port. The lower half maps onto the sixteen RAM bytes that start at 0x20. The upper half maps onto the SFRs whose address ends in 0x0 or 0x8. A bit modification reads the target byte, changes one bit and writes the byte back in the same cycle.

A small control machine tracks whether a response is pending. It has two states. `ST_IDLE` means no response is presented. `ST_RESP` means a response is presented this cycle. The transition named accept moves from either state to `ST_RESP` when `req_valid` is high. The transition named drain moves from `ST_RESP` to `ST_IDLE` when `req_valid` is low. The transition named hold keeps `ST_IDLE` while `req_valid` stays low.

Top module: `idata_access_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, the stack pointer holds 0x07, and every implemented SFR slot holds 0x00.
- R2: A direct byte access (req_op 0 = read, 1 = write) to an address below 0x80 reads or writes that RAM byte.
- R3: A direct byte access to an address from 0x80 to 0xFF reaches the SFR space and never RAM. The implemented SFR slots are the sixteen addresses whose low three bits are 000, and each keeps the last value written to it.
- R4: A direct read of an SFR address that is neither a slot nor the stack pointer returns 0x00. A direct write to such an address changes nothing.
- R5: An indirect byte access (req_op 2 = read, 3 = write) reaches RAM at any of the 256 addresses, including 0x80 to 0xFF.
- R6: A bit address b below 0x80 selects bit (b & 7) of RAM byte 0x20 + (b >> 3). For example, 0x13 selects bit 3 of byte 0x22.
- R7: A bit address b from 0x80 to 0xFF selects bit (b & 7) of the SFR at address (b & 0xF8).
- R8: Bit requests are req_op 4 = read, 5 = set, 6 = clear, and 7 = write the value of req_wdata bit 0. Set, clear and write change only the addressed bit, and they do so within the single request cycle. For every bit request, `rsp_bit` returns the bit's value before the request, and `rsp_rdata` returns the whole byte before the request.
- R9: A push (req_op 8) first increments the stack pointer and then writes req_wdata into RAM at the new value. The first push after reset writes RAM byte 0x08.
- R10: A pop (req_op 9) returns the RAM byte at the stack pointer in `rsp_rdata` and then decrements the stack pointer.
- R11: The stack pointer wraps modulo 256 on both push and pop, so the stack can use the full RAM.
- R12: The stack pointer can be read and written as the direct SFR address 0x81.
- R13: `rsp_valid` is high in the cycle after every cycle in which `req_valid` was high, and low otherwise. `rsp_rdata` is 0 after byte writes and pushes, and `rsp_bit` is 0 after non-bit requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Request kind, encoded as in R2, R5, R8, R9, R10 |
| req_addr | input | 8 | Byte address or bit address |
| req_wdata | input | 8 | Write or push data; bit 0 is the value for a bit write |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 8 | Byte read, popped value, or byte before a bit request |
| rsp_bit | output | 1 | Bit value before a bit request |

## Verification
The bench uses the default parameters: an 8-bit address, a stack-pointer reset value of 0x07, the stack pointer at SFR 0x81, and bit-addressable RAM starting at 0x20. With these values, every one of the 256 byte addresses in each access mode and every one of the 256 bit addresses can be swept in a few thousand cycles. The expected results come from arithmetic on the address. A stack pointer placed just below 0xFF brings the wrap in both directions into reach with only a handful of pushes and pops.

// File: rtl/idata_pkg.sv
package idata_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int BITPOS_W = $clog2(DATA_W);

    typedef enum logic [3:0] {
        OP_RD_DIR  = 4'd0,
        OP_WR_DIR  = 4'd1,
        OP_RD_IND  = 4'd2,
        OP_WR_IND  = 4'd3,
        OP_BIT_RD  = 4'd4,
        OP_BIT_SET = 4'd5,
        OP_BIT_CLR = 4'd6,
        OP_BIT_WR  = 4'd7,
        OP_PUSH    = 4'd8,
        OP_POP     = 4'd9
    } req_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic                to_sfr;
        logic [ADDR_W-1:0]   byte_addr;
        logic [BITPOS_W-1:0] bit_pos;
    } target_t;

endpackage

// File: rtl/idata_addr_map.sv
module idata_addr_map
    import idata_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20
) (
    input  req_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] sp,
    output target_t           tgt
);

    localparam int MSB = ADDR_W - 1;

    always_comb begin
        tgt           = '0;
        tgt.byte_addr = addr;
        case (op)
            OP_RD_DIR, OP_WR_DIR: begin
                tgt.to_sfr = addr[MSB];
            end
            OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_WR: begin
                tgt.to_sfr  = addr[MSB];
                tgt.bit_pos = addr[BITPOS_W-1:0];
                if (addr[MSB]) begin
                    tgt.byte_addr = {addr[MSB:BITPOS_W], {BITPOS_W{1'b0}}};
                end else begin
                    tgt.byte_addr = BIT_RAM_BASE + ADDR_W'(addr[MSB-1:BITPOS_W]);
                end
            end
            OP_PUSH: begin
                tgt.byte_addr = sp + ADDR_W'(1);
            end
            OP_POP: begin
                tgt.byte_addr = sp;
            end
            default: begin
                tgt.to_sfr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idata_ram.sv
module idata_ram
    import idata_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int RAM_DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/idata_sfr_bank.sv
module idata_sfr_bank
    import idata_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_ADDR  = 8'h81,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sp_we,
    input  logic [ADDR_W-1:0] sp_next,
    output logic [ADDR_W-1:0] sp
);

    localparam int MSB       = ADDR_W - 1;
    localparam int NUM_SLOTS = (1 << (ADDR_W - 1)) >> BITPOS_W;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    logic                           slot_hit;
    logic [SLOT_W-1:0]              slot_idx;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;

    assign slot_hit = addr[MSB] && (addr[BITPOS_W-1:0] == '0);
    assign slot_idx = addr[MSB-1:BITPOS_W];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && slot_hit && (slot_idx == SLOT_W'(g))) begin
                q <= wdata;
            end
        end
        assign slot_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RESET;
        end else if (sp_we) begin
            sp <= sp_next;
        end else if (we && (addr == SP_ADDR)) begin
            sp <= wdata;
        end
    end

    always_comb begin
        if (addr == SP_ADDR) begin
            rdata = sp;
        end else if (slot_hit) begin
            rdata = slot_q[slot_idx];
        end else begin
            rdata = '0;
        end
    end

    // R4: a write to an unimplemented SFR leaves the stack pointer alone
    p_unimpl_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (we && !sp_we && addr[MSB] && !slot_hit && (addr != SP_ADDR)) |=> (sp == $past(sp)));

endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
    import idata_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_RESET     = 8'h07,
    parameter logic [ADDR_W-1:0] SP_ADDR      = 8'h81,
    parameter logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_bit
);

    req_op_e           op;
    target_t           tgt;
    ctl_state_e        state_q, state_nx;
    logic [ADDR_W-1:0] sp_cur;
    logic [DATA_W-1:0] ram_rd, sfr_rd, src_byte, new_byte, mask;
    logic              is_bit, is_bit_mod, bit_old;
    logic              ram_we, sfr_we, sp_we;
    logic [ADDR_W-1:0] sp_nx;
    logic [DATA_W-1:0] rd_nx;
    logic              bit_nx;

    assign op = req_op_e'(req_op);

    idata_addr_map #(.BIT_RAM_BASE(BIT_RAM_BASE)) u_map (
        .op   (op),
        .addr (req_addr),
        .sp   (sp_cur),
        .tgt  (tgt)
    );

    idata_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (tgt.byte_addr),
        .wdata (is_bit_mod ? new_byte : req_wdata),
        .rdata (ram_rd)
    );

    idata_sfr_bank #(.SP_ADDR(SP_ADDR), .SP_RESET(SP_RESET)) u_sfr (
        .clk     (clk),
        .rst     (rst),
        .we      (sfr_we),
        .addr    (tgt.byte_addr),
        .wdata   (is_bit_mod ? new_byte : req_wdata),
        .rdata   (sfr_rd),
        .sp_we   (sp_we),
        .sp_next (sp_nx),
        .sp      (sp_cur)
    );

    // read-modify-write datapath
    assign is_bit_mod = (op == OP_BIT_SET) || (op == OP_BIT_CLR) || (op == OP_BIT_WR);
    assign is_bit     = is_bit_mod || (op == OP_BIT_RD);
    assign src_byte   = tgt.to_sfr ? sfr_rd : ram_rd;
    assign mask       = DATA_W'(1) << tgt.bit_pos;
    assign bit_old    = src_byte[tgt.bit_pos];

    always_comb begin
        unique case (op)
            OP_BIT_SET: new_byte = src_byte | mask;
            OP_BIT_CLR: new_byte = src_byte & ~mask;
            OP_BIT_WR:  new_byte = (src_byte & ~mask) | (req_wdata[0] ? mask : '0);
            default:    new_byte = src_byte;
        endcase
    end

    always_comb begin
        ram_we = 1'b0;
        sfr_we = 1'b0;
        sp_we  = 1'b0;
        sp_nx  = sp_cur;
        if (req_valid) begin
            unique case (op)
                OP_WR_DIR:  begin ram_we = !tgt.to_sfr; sfr_we = tgt.to_sfr; end
                OP_WR_IND:  ram_we = 1'b1;
                OP_BIT_SET,
                OP_BIT_CLR,
                OP_BIT_WR:  begin ram_we = !tgt.to_sfr; sfr_we = tgt.to_sfr; end
                OP_PUSH:    begin ram_we = 1'b1; sp_we = 1'b1; sp_nx = sp_cur + ADDR_W'(1); end
                OP_POP:     begin sp_we = 1'b1; sp_nx = sp_cur - ADDR_W'(1); end
                default:    ram_we = 1'b0;
            endcase
        end
    end

    always_comb begin
        unique case (op)
            OP_RD_DIR, OP_RD_IND, OP_POP,
            OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_WR: rd_nx = src_byte;
            default:                                      rd_nx = '0;
        endcase
        bit_nx = is_bit && bit_old;
    end

    // control state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE; // accept / hold
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE; // accept / drain
            default: state_nx = ST_IDLE;
        endcase
    end

    // response outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            rsp_bit   <= 1'b0;
        end else if (req_valid) begin
            rsp_rdata <= rd_nx;
            rsp_bit   <= bit_nx;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    p_rsp_follows_req_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    p_push_preinc_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_PUSH) |=> (sp_cur == $past(sp_cur) + ADDR_W'(1)));

    p_pop_postdec_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_POP) |=> (sp_cur == $past(sp_cur) - ADDR_W'(1)));

    p_single_bit_change_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_bit_mod) |-> ($countones(new_byte ^ src_byte) <= 1));

    p_unimpl_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op == OP_RD_DIR && req_addr[ADDR_W-1] &&
                            req_addr[BITPOS_W-1:0] != '0 && req_addr != SP_ADDR))
        |-> (rsp_rdata == '0));

endmodule

// File: tb/idata_access_unit_tb.sv
`timescale 1ns/1ps
module idata_access_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       rsp_bit;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] m_ram [256];
    logic [7:0] m_sfr [256];
    logic [7:0] m_sp;

    always #4 clk = ~clk;

    idata_access_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_bit   (rsp_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sfr_model_rd(input logic [7:0] x);
        if (x == 8'h81)            return m_sp;
        else if (x[2:0] == 3'b000) return m_sfr[x];
        else                       return 8'h00;
    endfunction

    task automatic do_reset();
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) m_sfr[i] = 8'h00;
        m_sp = 8'h07;
    endtask

    // apply one request, predict from the model, check after the response edge
    task automatic run(input int op, input int a, input int w, input string tag);
        logic [7:0] ad, wd, exp_rd, b, old, nw;
        logic       exp_bit;
        logic [2:0] pos;
        ad = 8'(a);
        wd = 8'(w);
        exp_rd = 8'h00;
        exp_bit = 1'b0;
        case (op)
            0: exp_rd = ad[7] ? sfr_model_rd(ad) : m_ram[ad];
            1: begin
                if (!ad[7])                 m_ram[ad] = wd;
                else if (ad == 8'h81)       m_sp = wd;
                else if (ad[2:0] == 3'b000) m_sfr[ad] = wd;
            end
            2: exp_rd = m_ram[ad];
            3: m_ram[ad] = wd;
            4, 5, 6, 7: begin
                b   = ad[7] ? {ad[7:3], 3'b000} : 8'h20 + {4'h0, ad[6:3]};
                pos = ad[2:0];
                old = ad[7] ? m_sfr[b] : m_ram[b];
                exp_rd  = old;
                exp_bit = old[pos];
                nw = old;
                if (op == 5) nw[pos] = 1'b1;
                if (op == 6) nw[pos] = 1'b0;
                if (op == 7) nw[pos] = wd[0];
                if (ad[7]) m_sfr[b] = nw;
                else       m_ram[b] = nw;
            end
            8: begin
                m_sp = m_sp + 8'd1;
                m_ram[m_sp] = wd;
            end
            9: begin
                exp_rd = m_ram[m_sp];
                m_sp = m_sp - 8'd1;
            end
            default: ;
        endcase
        req_valid = 1'b1;
        req_op    = 4'(op);
        req_addr  = ad;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 rsp_valid", int'(rsp_valid), 1);
        chk(tag, int'(rsp_rdata), int'(exp_rd));
        chk(tag, int'(rsp_bit), int'(exp_bit));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R13 watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        run(0, 8'h81, 0, "R1 sp reset");
        for (int s = 0; s < 16; s++) run(0, 8'h80 + s * 8, 0, "R1 slot reset");

        // R5: indirect fill and read of the whole RAM
        for (int i = 0; i < 256; i++) run(3, i, (i * 37 + 11) & 255, "R5");
        for (int i = 0; i < 256; i++) run(2, i, 0, "R5");

        // R2: direct lower half
        for (int i = 0; i < 128; i++) run(1, i, i ^ 8'h5A, "R2");
        for (int i = 0; i < 128; i++) run(0, i, 0, "R2");

        // R3 / R4: direct SFR sweep (stack pointer left alone here)
        for (int a = 128; a < 256; a++)
            if (a != 8'h81) run(1, a, a ^ 8'hC3, "R3 write");
        for (int a = 128; a < 256; a++)
            run(0, a, 0, ((a & 7) == 0 || a == 8'h81) ? "R3 read" : "R4 unimplemented");
        for (int a = 128; a < 256; a++) run(2, a, 0, "R3 upper RAM untouched");

        // R6 / R8: every bit of the bit-addressable RAM
        for (int b = 0; b < 128; b++) begin
            run(6, b, 0, "R8 clear");
            run(5, b, 0, "R6 set");
            run(0, 8'h20 + b / 8, 0, "R6 byte");
            run(7, b, 0, "R8 write0");
            run(7, b, 1, "R8 write1");
            run(4, b, 0, "R8 bit read");
        end
        for (int i = 8'h1F; i <= 8'h30; i++) run(0, i, 0, "R6 neighbours");

        // R7: every bit of the bit-addressable SFRs
        for (int b = 128; b < 256; b++) begin
            run(5, b, 0, "R7 set");
            run(4, b, 0, "R7 read");
            run(6, b, 0, "R7 clear");
            run(7, b, (b >> 1) & 1, "R7 write");
            run(0, b & 8'hF8, 0, "R7 byte");
        end

        // R9..R12: stack
        do_reset();
        run(8, 0, 8'hA1, "R9 first push");
        run(2, 8'h08, 0, "R9 lands at 0x08");
        run(0, 8'h81, 0, "R12 sp read");
        run(8, 0, 8'hB2, "R9 push");
        run(9, 0, 0, "R10 pop");
        run(9, 0, 0, "R10 pop");
        run(0, 8'h81, 0, "R12 sp after pops");
        run(1, 8'h81, 8'hFD, "R12 sp write");
        for (int k = 0; k < 5; k++) run(8, 0, 8'h60 + k, "R11 push wrap");
        run(0, 8'h81, 0, "R11 sp wrapped");
        run(2, 8'h00, 0, "R11 wrapped byte");
        run(2, 8'hFF, 0, "R11 top byte");
        for (int k = 0; k < 5; k++) run(9, 0, 0, "R11 pop wrap");
        run(1, 8'h81, 8'h00, "R12 sp write zero");
        run(9, 0, 0, "R11 pop from zero");
        run(0, 8'h81, 0, "R11 sp underflow");

        @(negedge clk);
        chk("R13 idle rsp_valid", int'(rsp_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule